// File: doc/BRIEF.md
# Multi-Context Load-Reservation Monitor

This block tracks one load reservation for each hardware thread context of a core. Each context owns a valid flag and the address of a reserved memory block. All requests arrive on one shared port that carries a context number, an operation code, a physical address and an uncacheable marker. A load-locked request arms the reservation of the issuing context. A store-conditional is judged against that reservation, and the block answers with a result code in the same cycle.

Reservations are compared at block granularity, 16 bytes by default. Every store that actually writes memory drops the matching reservation in every context. The only signal toward memory is a write-enable that says whether the store goes ahead. Each context also counts its store-conditional failures in a row. When that count reaches a multiple of a fixed interval, the block raises a one-cycle warning tagged with the context number, as a hint that software may be livelocked.

Top module: `resv_monitor`

## Requirements
- R1: A valid load-locked request (op code 1) sets the flag of the issuing context and records the block address, which is the request address with its low BLOCK_BITS (default 4) bits dropped.
- R2: A valid cacheable store-conditional (op code 3) succeeds when the issuing context's flag is set and its recorded block equals the block of the store address, whatever the low BLOCK_BITS bits are. It then reports result 1 and asserts mem_we.
- R3: A cacheable store-conditional that does not succeed reports result 0, keeps mem_we low, and clears the issuing context's flag.
- R4: A store-conditional with req_uncached high reports result 2 without being judged, asserts mem_we, and resets that context's failure count to zero.
- R5: Every request that asserts mem_we clears the flag of every context, the issuer included, whose recorded block equals the store's block. This covers an ordinary store (op code 2), a successful store-conditional and an uncacheable store-conditional.
- R6: A failed store-conditional adds one to the issuing context's consecutive-failure count, and a successful cacheable one resets it to zero. When a failure brings the count to a multiple of WARN_INTERVAL (default 100000), warn_pulse is high in that cycle and warn_ctx holds the context number.
- R7: sc_valid, sc_result, mem_we and warn_pulse depend on the request in the same cycle, and the state change takes effect at the next clock edge. When sc_valid is low, sc_result is 0.
- R8: An ordinary store asserts mem_we. A plain load (op code 0), or any request with req_valid low, leaves mem_we low and changes no reservation or count.
- R9: After reset every flag is clear and every failure count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_ctx | input | CTX_W | Issuing context number |
| req_op | input | 2 | 0 load, 1 load-locked, 2 store, 3 store-conditional |
| req_addr | input | AW | Physical address |
| req_uncached | input | 1 | Request targets uncacheable space |
| sc_valid | output | 1 | A store-conditional is answered this cycle |
| sc_result | output | 2 | 0 failed, 1 succeeded, 2 uncacheable |
| mem_we | output | 1 | Memory should perform the store |
| warn_pulse | output | 1 | Failure count reached a multiple of WARN_INTERVAL |
| warn_ctx | output | CTX_W | Context that raised the warning |

## Verification
A flag that is set or cleared wrongly shows up at the next store-conditional from that context, as result 1 where 0 is due or the other way round. mem_we follows the same result in that same cycle. A wrong block address shows up when a store-conditional lands in a neighbouring block, or in the same block with different low bits. A failure count that drifts shows up only when the warning fires, so the bench uses a short interval that exposes a drift within a few failures.

// File: rtl/resv_pkg.sv
package resv_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_LL    = 2'd1,
      OP_STORE = 2'd2,
      OP_SC    = 2'd3
   } resv_op_e;

   localparam logic [1:0] SC_FAIL   = 2'd0;
   localparam logic [1:0] SC_OK     = 2'd1;
   localparam logic [1:0] SC_UNCACH = 2'd2;
endpackage

// File: rtl/resv_slot.sv
module resv_slot #(
   parameter int BW = 28
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_i,
   input  logic          clr_i,
   input  logic [BW-1:0] blk_i,
   output logic          match_o,
   output logic          flag_o
);
   logic          flag_q;
   logic [BW-1:0] blk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         blk_q  <= '0;
      end else begin
         // invalidation first, new reservation last
         if (clr_i) flag_q <= 1'b0;
         if (set_i) begin
            flag_q <= 1'b1;
            blk_q  <= blk_i;
         end
      end
   end

   assign match_o = flag_q && (blk_q == blk_i);
   assign flag_o  = flag_q;

   p_set_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (flag_o && blk_q == $past(blk_i)));
   p_clr_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/resv_fail_cnt.sv
module resv_fail_cnt #(
   parameter int INTERVAL = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fail_i,
   input  logic zero_i,
   output logic warn_o
);
   localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
   localparam bit POW2 = (INTERVAL & (INTERVAL - 1)) == 0;

   logic [CW-1:0] cnt_q;
   logic          at_top;

   generate
      if (POW2) begin : g_pow2
         assign at_top = &cnt_q;
      end else begin : g_cmp
         assign at_top = (cnt_q == CW'(INTERVAL - 1));
      end
   endgenerate

   assign warn_o = fail_i && at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (zero_i) cnt_q <= '0;
      else if (fail_i) cnt_q <= at_top ? '0 : cnt_q + 1'b1;
   end

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(INTERVAL - 1) || cnt_q == CW'(INTERVAL - 1));
   p_warn_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      warn_o |=> (cnt_q == '0));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
   parameter int NCTX          = 4,
   parameter int AW            = 32,
   parameter int BLOCK_BITS    = 4,
   parameter int WARN_INTERVAL = 100000,
   parameter int CTX_W         = $clog2(NCTX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [CTX_W-1:0] req_ctx,
   input  logic [1:0]       req_op,
   input  logic [AW-1:0]    req_addr,
   input  logic             req_uncached,
   output logic             sc_valid,
   output logic [1:0]       sc_result,
   output logic             mem_we,
   output logic             warn_pulse,
   output logic [CTX_W-1:0] warn_ctx
);
   import resv_pkg::*;

   localparam int BW = AW - BLOCK_BITS;

   initial begin
      if (NCTX < 2)                   $error("NCTX must be at least 2");
      if (BLOCK_BITS < 0 || BW < 1)   $error("BLOCK_BITS out of range");
      if (WARN_INTERVAL < 2)          $error("WARN_INTERVAL must be at least 2");
      if (CTX_W < $clog2(NCTX))       $error("CTX_W too narrow");
   end

   logic [BW-1:0]   blk;
   logic [NCTX-1:0] sel, match, flag, set_v, clr_v, warn_v, fail_v, zero_v;
   logic is_ll, is_st, is_sc, own_hit, sc_ok, sc_fail;

   assign blk     = req_addr[AW-1:BLOCK_BITS];
   assign is_ll   = req_valid && (req_op == OP_LL);
   assign is_st   = req_valid && (req_op == OP_STORE);
   assign is_sc   = req_valid && (req_op == OP_SC);
   assign own_hit = |(sel & match);
   assign sc_ok   = is_sc && !req_uncached && own_hit;
   assign sc_fail = is_sc && !req_uncached && !own_hit;

   assign sc_valid  = is_sc;
   assign sc_result = !is_sc       ? SC_FAIL :
                      req_uncached ? SC_UNCACH :
                      own_hit      ? SC_OK : SC_FAIL;
   assign mem_we    = is_st || (is_sc && (req_uncached || own_hit));

   genvar gi;
   generate
      for (gi = 0; gi < NCTX; gi++) begin : g_ctx
         assign sel[gi]    = (req_ctx == CTX_W'(gi));
         assign set_v[gi]  = is_ll && sel[gi];
         assign clr_v[gi]  = (mem_we && match[gi]) || (sc_fail && sel[gi]);
         assign fail_v[gi] = sc_fail && sel[gi];
         assign zero_v[gi] = is_sc && sel[gi] && (req_uncached || own_hit);

         resv_slot #(.BW(BW)) u_slot (
            .clk(clk), .rst_n(rst_n), .set_i(set_v[gi]), .clr_i(clr_v[gi]),
            .blk_i(blk), .match_o(match[gi]), .flag_o(flag[gi]));

         resv_fail_cnt #(.INTERVAL(WARN_INTERVAL)) u_cnt (
            .clk(clk), .rst_n(rst_n), .fail_i(fail_v[gi]), .zero_i(zero_v[gi]),
            .warn_o(warn_v[gi]));
      end
   endgenerate

   assign warn_pulse = |warn_v;
   assign warn_ctx   = req_ctx;

   p_uncached_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_valid && req_uncached) |-> (sc_result == SC_UNCACH && mem_we));
   p_fail_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_valid && sc_result == SC_FAIL) |-> !mem_we);
   p_warn_on_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      warn_pulse |-> (sc_valid && sc_result == SC_FAIL && $onehot(warn_v)));
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!mem_we && !sc_valid && !warn_pulse));
   p_success_needs_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_valid && sc_result == SC_OK) |-> (|flag));
endmodule

// File: tb/sim_resv_monitor.sv
`timescale 1ns/1ps
module sim_resv_monitor;
   localparam int NCTX = 4;
   localparam int AW   = 32;
   localparam int WI   = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_ctx = '0;
   logic [1:0] req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic req_uncached = 1'b0;
   logic sc_valid, mem_we, warn_pulse;
   logic [1:0] sc_result, warn_ctx;

   int n_tests = 0;
   int n_fail  = 0;
   bit         m_flag [NCTX];
   logic [27:0] m_blk [NCTX];
   int         m_cnt [NCTX];

   always #2.5 clk = ~clk;

   resv_monitor #(.NCTX(NCTX), .AW(AW), .BLOCK_BITS(4), .WARN_INTERVAL(WI)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
      .req_op(req_op), .req_addr(req_addr), .req_uncached(req_uncached),
      .sc_valid(sc_valid), .sc_result(sc_result), .mem_we(mem_we),
      .warn_pulse(warn_pulse), .warn_ctx(warn_ctx));

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] exp_res(bit v, int c, int op, logic [AW-1:0] a, bit u);
      if (!(v && op == 3)) return 2'd0;
      if (u) return 2'd2;
      return (m_flag[c] && m_blk[c] == a[AW-1:4]) ? 2'd1 : 2'd0;
   endfunction

   // drive at negedge, check before posedge, then advance model past posedge
   task automatic do_op(bit v, int c, int op, logic [AW-1:0] a, bit u, string tag);
      logic [1:0] er;
      bit ewe, ewarn;
      @(negedge clk);
      req_valid = v; req_ctx = 2'(c); req_op = 2'(op); req_addr = a; req_uncached = u;
      er    = exp_res(v, c, op, a, u);
      ewe   = v && (op == 2 || (op == 3 && (u || er == 2'd1)));
      ewarn = v && op == 3 && !u && er == 2'd0 && m_cnt[c] == WI - 1;
      #1;
      chk({tag, " R7 sc_valid"}, 8'(sc_valid), 8'(v && op == 3));
      chk({tag, (op == 3 && u) ? " R4 result" : (er == 2'd1 ? " R2 result" : " R3 result")},
          8'(sc_result), 8'(er));
      chk({tag, (op == 2) ? " R8 mem_we" : " R3 mem_we"}, 8'(mem_we), 8'(ewe));
      chk({tag, " R6 warn"}, 8'(warn_pulse), 8'(ewarn));
      if (ewarn) chk({tag, " R6 warn_ctx"}, 8'(warn_ctx), 8'(c));
      if (v) begin
         if (ewe)
            for (int i = 0; i < NCTX; i++)
               if (m_flag[i] && m_blk[i] == a[AW-1:4]) m_flag[i] = 1'b0;
         if (op == 3 && !u && er == 2'd0) begin
            m_flag[c] = 1'b0;
            m_cnt[c]  = (m_cnt[c] == WI - 1) ? 0 : m_cnt[c] + 1;
         end
         if (op == 3 && (u || er == 2'd1)) m_cnt[c] = 0;
         if (op == 1) begin m_flag[c] = 1'b1; m_blk[c] = a[AW-1:4]; end
      end
   endtask

   initial begin
      #150000;
      n_fail++;
      $display("FAIL watchdog R7 actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [AW-1:0] pool [4];
      void'($urandom(32'd1234));
      pool[0] = 32'h0000_1000; pool[1] = 32'h0000_1010;
      pool[2] = 32'h0000_2000; pool[3] = 32'h8000_0030;
      for (int i = 0; i < NCTX; i++) begin m_flag[i] = 0; m_blk[i] = '0; m_cnt[i] = 0; end
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R9: right after reset no context holds a reservation
      for (int c = 0; c < NCTX; c++) do_op(1, c, 3, 32'h0000_1000, 0, "R9 reset");
      // R1/R2: reserve then succeed with different low bits
      do_op(1, 1, 1, 32'h0000_1004, 0, "R1 ll");
      do_op(1, 1, 3, 32'h0000_100C, 0, "R2 sc same block");
      // R5: store from another context kills the reservation
      do_op(1, 2, 1, 32'h0000_2000, 0, "R1 ll");
      do_op(1, 0, 2, 32'h0000_200F, 0, "R5 store");
      do_op(1, 2, 3, 32'h0000_2000, 0, "R5 sc after store");
      // R2 boundary: neighbouring block fails
      do_op(1, 3, 1, 32'h0000_1000, 0, "R1 ll");
      do_op(1, 3, 3, 32'h0000_1010, 0, "R3 neighbour block");
      do_op(1, 3, 3, 32'h0000_1000, 0, "R3 flag cleared");
      // R8: invalid and plain-load requests change nothing
      do_op(1, 0, 1, 32'h0000_3000, 0, "R1 ll");
      do_op(0, 1, 2, 32'h0000_3000, 0, "R8 invalid store");
      do_op(1, 1, 0, 32'h0000_3000, 0, "R8 load");
      do_op(1, 0, 3, 32'h0000_3000, 0, "R8 reservation kept");
      // R4: uncached SC; then R6 failure run to the warning
      do_op(1, 2, 3, 32'h0000_4000, 1, "R4 uncached");
      for (int k = 0; k < WI + 2; k++) do_op(1, 2, 3, 32'h0000_5000, 0, "R6 fail run");
      // R5: successful SC also drops other contexts' matching reservations
      do_op(1, 0, 1, 32'h0000_6000, 0, "R1 ll");
      do_op(1, 1, 1, 32'h0000_6008, 0, "R1 ll");
      do_op(1, 0, 3, 32'h0000_6000, 0, "R2 sc");
      do_op(1, 1, 3, 32'h0000_6000, 0, "R5 peer dropped");
      // random mix
      for (int k = 0; k < 3000; k++) begin
         logic [AW-1:0] a;
         a = pool[$urandom_range(0, 3)] | AW'($urandom_range(0, 15));
         do_op(($urandom_range(0, 9) != 0), $urandom_range(0, NCTX - 1),
               $urandom_range(0, 3), a, ($urandom_range(0, 15) == 0), "rand");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule